// File: doc/BRIEF.md
# Four-Input Event Fragment Merger

This block collects event fragments arriving on four independent input channels and stitches them into a single nested output packet. Each input fragment is framed as a first header word, a second header word, zero or more payload words and a trailer; the last word of a fragment is marked by the input's `last` strobe. Every channel has its own small buffer that holds whole fragments together with their word counts, so the merger can check and size the packet before it sends anything.

When every enabled channel holds at least one complete fragment, the block emits a two-word merger header and then, for each enabled channel in ascending channel order, that channel's head fragment unchanged, closed by a constant end-of-fragment word. A control word disables channels one by one, and a second control word sets a bunch-count offset applied to the merger header. The block compares the bunch count and buffer number of all enabled inputs and reports disagreements in the merger's second header word.

Top module: `frag_merge`

## Requirements
- R1: A packet is emitted as merger header 1, merger header 2, then for each enabled channel from 0 up to 3 its whole head fragment (header 1, header 2, payload, trailer) in arrival order, each followed by one end-of-fragment word.
- R2: The end-of-fragment word is 0xE0F00000.
- R3: Merger header 1 is {VER[31:28], SRC[27:24], REGION[23:16], bunch[15:8], 6'b0, buffer[1:0]}, where bunch is the lowest enabled channel's bunch count (its header 1 bits 15:8) plus the shift control value modulo 256, and buffer is that channel's header 1 bits 1:0.
- R4: Merger header 2 bits 31:16 hold the total packet length in words (2 + the sum over enabled channels of fragment length + 1); bits 15:0 hold the error flags.
- R5: Error flag bit 0 is set when an enabled channel's bunch count differs from the lowest enabled channel's; bit 1 is set when a buffer number differs; other flag bits are 0.
- R6: Control bit n high disables channel n, which then contributes no word to the packet; after reset the disable word is 0 (all enabled) and the bunch-count shift is 41.
- R7: No packet starts until every enabled channel has a complete fragment buffered; with all four channels disabled no output appears and buffered fragments are kept for later packets.
- R8: Once started, a packet is emitted one word per cycle with no idle cycle, and `out_last` is high only on its final end-of-fragment word.
- R9: A channel deasserts `in_ready` while its buffer is full; words offered while `in_ready` is low are not taken and no accepted word is lost. A fragment may be at most DEPTH words long.
- R10: During and right after reset `out_valid` is low and all `in_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Loads both control words |
| ctl_disable | input | NCH | Per-channel disable bits, high disables |
| ctl_bc_shift | input | 8 | Offset added to the bunch count in merger header 1 |
| in_valid | input | NCH | Per-channel word valid |
| in_last | input | NCH | Per-channel last word of fragment (trailer) |
| in_data | input | NCH*W | Per-channel data, channel c at bits c*W +: W |
| in_ready | output | NCH | Per-channel buffer can accept a word |
| out_valid | output | 1 | Output word valid |
| out_data | output | W | Output word |
| out_last | output | 1 | Final word of the merged packet |

## Verification
The bench aims at the header arithmetic corners: a bunch count whose sum with the shift wraps past 255, a mismatch appearing only on a later channel, and masks whose lowest enabled channel is not channel 0; a design that took the reference from channel 0 regardless of the mask, or forgot the wrap, would put the wrong bunch count or flags in the merger header. It holds back one channel while the others are complete and masks all channels with fragments waiting, where an eager sequencer would start early or drop the held fragments. Long fragments with a late channel force the per-channel buffers full, where a buffer that ignored its fill level would overwrite words and corrupt the payload. Every output word is compared with a queue built from the requirements, and any idle cycle inside a packet or a misplaced last strobe is reported.

// File: rtl/frag_merge_pkg.sv
package frag_merge_pkg;

  localparam logic [31:0] EOF_WORD = 32'hE0F0_0000;

  // Input header 1 field extraction
  function automatic logic [7:0] hdr_bunch(input logic [31:0] w);
    return w[15:8];
  endfunction

  function automatic logic [1:0] hdr_bufnum(input logic [31:0] w);
    return w[1:0];
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MH1  = 3'd1,
    ST_MH2  = 3'd2,
    ST_BODY = 3'd3,
    ST_EOF  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/frag_merge_fifo.sv
module frag_merge_fifo #(
  parameter int W      = 32,
  parameter int DEPTH  = 16,
  parameter int LDEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  input  logic                             wr_last,
  input  logic [W-1:0]                     wr_data,
  output logic                             wr_ready,
  input  logic                             rd_pop,
  output logic [W-1:0]                     rd_data,
  output logic                             rd_last,
  output logic                             frag_avail,
  output logic [$clog2(DEPTH+1)-1:0]       frag_len
);

  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = $clog2(DEPTH+1);
  localparam int LAW = $clog2(LDEPTH);
  localparam logic [AW:0]  FULL_CNT  = (AW+1)'(DEPTH);
  localparam logic [LAW:0] LFULL_CNT = (LAW+1)'(LDEPTH);

  logic [W:0]     mem  [DEPTH];
  logic [LW-1:0]  lmem [LDEPTH];

  logic [AW-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]    cnt_q, cnt_d;
  logic [LAW-1:0] lwp_q, lwp_d, lrp_q, lrp_d;
  logic [LAW:0]   lcnt_q, lcnt_d;
  logic [LW-1:0]  wlen_q, wlen_d;

  logic push, pop, lpush, lpop;

  assign wr_ready   = (cnt_q != FULL_CNT) && (lcnt_q != LFULL_CNT);
  assign push       = wr_valid && wr_ready;
  assign pop        = rd_pop;
  assign lpush      = push && wr_last;
  assign lpop       = rd_pop && rd_last;

  assign rd_data    = mem[rp_q][W-1:0];
  assign rd_last    = mem[rp_q][W];
  assign frag_avail = (lcnt_q != '0);
  assign frag_len   = lmem[lrp_q];

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    lwp_d  = lwp_q;
    lrp_d  = lrp_q;
    lcnt_d = lcnt_q;
    wlen_d = wlen_q;
    if (push) begin
      wp_d   = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      wlen_d = wr_last ? '0 : wlen_q + 1'b1;
    end
    if (pop) begin
      rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    end
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && pop) cnt_d = cnt_q - 1'b1;
    if (lpush) lwp_d = (lwp_q == LAW'(LDEPTH-1)) ? '0 : lwp_q + 1'b1;
    if (lpop)  lrp_d = (lrp_q == LAW'(LDEPTH-1)) ? '0 : lrp_q + 1'b1;
    if (lpush && !lpop)      lcnt_d = lcnt_q + 1'b1;
    else if (!lpush && lpop) lcnt_d = lcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      lwp_q  <= '0;
      lrp_q  <= '0;
      lcnt_q <= '0;
      wlen_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      lwp_q  <= lwp_d;
      lrp_q  <= lrp_d;
      lcnt_q <= lcnt_d;
      wlen_q <= wlen_d;
    end
  end

  // Storage arrays: no reset, written under their enables
  always_ff @(posedge clk) begin
    if (push)  mem[wp_q]   <= {wr_last, wr_data};
    if (lpush) lmem[lwp_q] <= wlen_q + 1'b1;
  end

endmodule

// File: rtl/frag_merge_hdr.sv
module frag_merge_hdr #(
  parameter int         NCH    = 4,
  parameter int         W      = 32,
  parameter int         LW     = 5,
  parameter logic [3:0] VER    = 4'h2,
  parameter logic [3:0] SRC    = 4'hA,
  parameter logic [7:0] REGION = 8'h5C
) (
  input  logic [NCH-1:0] en,
  input  logic [7:0]     bunch [NCH],
  input  logic [1:0]     bufnum [NCH],
  input  logic [LW-1:0]  len [NCH],
  input  logic [7:0]     bc_shift,
  output logic [W-1:0]   mh1,
  output logic [W-1:0]   mh2
);

  logic        found;
  logic [7:0]  ref_bc;
  logic [1:0]  ref_buf;
  logic        bc_mis, buf_mis;
  logic [15:0] size;

  always_comb begin
    found   = 1'b0;
    ref_bc  = '0;
    ref_buf = '0;
    bc_mis  = 1'b0;
    buf_mis = 1'b0;
    size    = 16'd2;
    for (int c = 0; c < NCH; c++) begin
      if (en[c]) begin
        if (!found) begin
          found   = 1'b1;
          ref_bc  = bunch[c];
          ref_buf = bufnum[c];
        end else begin
          if (bunch[c] != ref_bc)   bc_mis  = 1'b1;
          if (bufnum[c] != ref_buf) buf_mis = 1'b1;
        end
        size = size + 16'(len[c]) + 16'd1;
      end
    end
    mh1 = W'({VER, SRC, REGION, 8'(ref_bc + bc_shift), 6'b0, ref_buf});
    mh2 = W'({size, 14'b0, buf_mis, bc_mis});
  end

endmodule

// File: rtl/frag_merge_seq.sv
module frag_merge_seq
  import frag_merge_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] avail,
  input  logic [W-1:0]   mh1,
  input  logic [W-1:0]   mh2,
  input  logic [W-1:0]   head_data [NCH],
  input  logic [NCH-1:0] head_last,
  output logic [NCH-1:0] pop,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           out_last
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [NCH-1:0] pen_q, pen_d;
  logic [W-1:0]   h1_q, h2_q;
  logic           hdr_load;
  logic           go;
  logic [CHW-1:0] first_ch, next_ch;
  logic           next_found;

  assign go = (|en) && ((en & ~avail) == '0);

  always_comb begin
    first_ch   = '0;
    next_ch    = '0;
    next_found = 1'b0;
    for (int c = NCH-1; c >= 0; c--) begin
      if (pen_q[c]) first_ch = CHW'(c);
    end
    for (int c = 0; c < NCH; c++) begin
      if (pen_q[c] && (CHW'(c) > ch_q) && !next_found) begin
        next_ch    = CHW'(c);
        next_found = 1'b1;
      end
    end
  end

  always_comb begin
    state_d   = state_q;
    ch_d      = ch_q;
    pen_d     = pen_q;
    hdr_load  = 1'b0;
    pop       = '0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          hdr_load = 1'b1;
          pen_d    = en;
          state_d  = ST_MH1;
        end
      end
      ST_MH1: begin
        out_valid = 1'b1;
        out_data  = h1_q;
        state_d   = ST_MH2;
      end
      ST_MH2: begin
        out_valid = 1'b1;
        out_data  = h2_q;
        ch_d      = first_ch;
        state_d   = ST_BODY;
      end
      ST_BODY: begin
        out_valid  = 1'b1;
        out_data   = head_data[ch_q];
        pop[ch_q]  = 1'b1;
        if (head_last[ch_q]) state_d = ST_EOF;
      end
      ST_EOF: begin
        out_valid = 1'b1;
        out_data  = W'(EOF_WORD);
        if (next_found) begin
          ch_d    = next_ch;
          state_d = ST_BODY;
        end else begin
          out_last = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      pen_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      pen_q   <= pen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hdr_load) begin
      h1_q <= mh1;
      h2_q <= mh2;
    end
  end

endmodule

// File: rtl/frag_merge.sv
module frag_merge
  import frag_merge_pkg::*;
#(
  parameter int         NCH       = 4,
  parameter int         W         = 32,
  parameter int         DEPTH     = 16,
  parameter int         LDEPTH    = 4,
  parameter logic [3:0] VER       = 4'h2,
  parameter logic [3:0] SRC       = 4'hA,
  parameter logic [7:0] REGION    = 8'h5C,
  parameter logic [7:0] SHIFT_RST = 8'd41
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [NCH-1:0] ctl_disable,
  input  logic [7:0]     ctl_bc_shift,
  input  logic [NCH-1:0] in_valid,
  input  logic [NCH-1:0] in_last,
  input  logic [NCH*W-1:0] in_data,
  output logic [NCH-1:0] in_ready,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic           out_last
);

  localparam int LW = $clog2(DEPTH+1);

  logic [NCH-1:0] mask_q, mask_d;
  logic [7:0]     shift_q, shift_d;

  logic [W-1:0]   rd_data [NCH];
  logic [NCH-1:0] rd_last;
  logic [NCH-1:0] avail;
  logic [LW-1:0]  flen [NCH];
  logic [NCH-1:0] pop;
  logic [7:0]     h_bunch [NCH];
  logic [1:0]     h_buf [NCH];
  logic [W-1:0]   mh1, mh2;

  always_comb begin
    mask_d  = mask_q;
    shift_d = shift_q;
    if (ctl_we) begin
      mask_d  = ctl_disable;
      shift_d = ctl_bc_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      shift_q <= SHIFT_RST;
    end else begin
      mask_q  <= mask_d;
      shift_q <= shift_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    frag_merge_fifo #(.W(W), .DEPTH(DEPTH), .LDEPTH(LDEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (in_valid[c]),
      .wr_last    (in_last[c]),
      .wr_data    (in_data[c*W +: W]),
      .wr_ready   (in_ready[c]),
      .rd_pop     (pop[c]),
      .rd_data    (rd_data[c]),
      .rd_last    (rd_last[c]),
      .frag_avail (avail[c]),
      .frag_len   (flen[c])
    );
    assign h_bunch[c] = hdr_bunch(rd_data[c]);
    assign h_buf[c]   = hdr_bufnum(rd_data[c]);
  end

  frag_merge_hdr #(
    .NCH(NCH), .W(W), .LW(LW), .VER(VER), .SRC(SRC), .REGION(REGION)
  ) u_hdr (
    .en       (~mask_q),
    .bunch    (h_bunch),
    .bufnum   (h_buf),
    .len      (flen),
    .bc_shift (shift_q),
    .mh1      (mh1),
    .mh2      (mh2)
  );

  frag_merge_seq #(.NCH(NCH), .W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (~mask_q),
    .avail     (avail),
    .mh1       (mh1),
    .mh2       (mh2),
    .head_data (rd_data),
    .head_last (rd_last),
    .pop       (pop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

endmodule

// File: rtl/frag_merge_chk.sv
module frag_merge_chk
  import frag_merge_pkg::*;
#(
  parameter int         NCH = 4,
  parameter int         W   = 32,
  parameter logic [3:0] VER = 4'h2,
  parameter logic [3:0] SRC = 4'hA
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic [W-1:0]   out_data,
  input logic           out_last,
  input logic [NCH-1:0] mask_q
);

  logic in_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_pkt <= 1'b0;
    else if (out_valid) in_pkt <= !out_last;
  end

  assert_eof_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data == W'(EOF_WORD)));

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  assert_first_is_merger_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_pkt) |-> (out_data[31:28] == VER && out_data[27:24] == SRC));

  assert_all_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q == '1) && !out_valid) |=> !out_valid);

  assert_last_only_in_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

bind frag_merge frag_merge_chk #(.NCH(NCH), .W(W), .VER(VER), .SRC(SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .mask_q    (mask_q)
);

// File: tb/frag_merge_test.sv
`timescale 1ns/1ps
module frag_merge_test;

  localparam int         NCH    = 4;
  localparam int         W      = 32;
  localparam logic [3:0] VER    = 4'h2;
  localparam logic [3:0] SRC    = 4'hA;
  localparam logic [7:0] REGION = 8'h5C;
  localparam logic [31:0] EOFW  = 32'hE0F00000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           ctl_we;
  logic [3:0]     ctl_disable;
  logic [7:0]     ctl_bc_shift;
  logic [3:0]     tb_v;
  logic [3:0]     tb_l;
  logic [W-1:0]   tb_d [4];
  logic [4*W-1:0] in_data;
  logic [3:0]     in_ready;
  logic           out_valid;
  logic [W-1:0]   out_data;
  logic           out_last;

  assign in_data = {tb_d[3], tb_d[2], tb_d[1], tb_d[0]};

  frag_merge #(.NCH(NCH), .W(W), .DEPTH(16), .LDEPTH(4), .VER(VER), .SRC(SRC),
               .REGION(REGION), .SHIFT_RST(8'd41)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_disable(ctl_disable),
    .ctl_bc_shift(ctl_bc_shift), .in_valid(tb_v), .in_last(tb_l),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  bit any_valid;
  bit saw_full0;
  bit pend;

  logic [32:0] chq [4][$];
  logic [32:0] exp_q [$];
  string       tag_q [$];

  int rbc [4];
  int rbf [4];
  int rln [4];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] frag_word(int c, int k, int j, int len, int bc, int bf);
    if (j == 0)            return {4'h1, 4'(c+2), 8'(k), 8'(bc), 6'b0, 2'(bf)};
    else if (j == 1)       return {16'(len), 16'h0};
    else if (j == len - 1) return {8'hFE, 8'(c), 16'(k)};
    else                   return {4'(c), 12'(k), 16'(j)};
  endfunction

  task automatic gen_frag(input int c, input int k);
    for (int j = 0; j < rln[c]; j++)
      chq[c].push_back({(j == rln[c]-1), frag_word(c, k, j, rln[c], rbc[c], rbf[c])});
  endtask

  task automatic exp_push(input logic [31:0] w, input bit last, input string tag);
    exp_q.push_back({last, w});
    tag_q.push_back(tag);
  endtask

  task automatic build_exp(input logic [3:0] dis, input logic [7:0] sh, input int k, input string h1tag);
    int first = -1;
    int lastc = -1;
    logic [15:0] size = 16'd2;
    logic [15:0] flags = 16'd0;
    for (int c = 0; c < 4; c++) begin
      if (!dis[c]) begin
        if (first < 0) first = c;
        else begin
          if (rbc[c] != rbc[first]) flags[0] = 1'b1;
          if (rbf[c] != rbf[first]) flags[1] = 1'b1;
        end
        size  = size + 16'(rln[c]) + 16'd1;
        lastc = c;
      end
    end
    if (first < 0) return;
    exp_push({VER, SRC, REGION, 8'(8'(rbc[first]) + sh), 6'b0, 2'(rbf[first])}, 0, h1tag);
    exp_push({size, flags}, 0, (flags != 0) ? "R5" : "R4");
    for (int c = 0; c < 4; c++) begin
      if (!dis[c]) begin
        for (int j = 0; j < rln[c]; j++)
          exp_push(frag_word(c, k, j, rln[c], rbc[c], rbf[c]), 0, "R1");
        exp_push(EOFW, (c == lastc), "R2");
      end
    end
  endtask

  task automatic drive_ch(input int c, input int delay);
    repeat (delay) @(negedge clk);
    while (chq[c].size() > 0) begin
      @(negedge clk);
      tb_v[c] = 1'b1;
      tb_d[c] = chq[c][0][31:0];
      tb_l[c] = chq[c][0][32];
      #1;
      if (in_ready[c]) begin
        void'(chq[c].pop_front());
        if ($urandom_range(0, 3) == 0) begin
          @(negedge clk);
          tb_v[c] = 1'b0;
        end
      end
    end
    @(negedge clk);
    tb_v[c] = 1'b0;
  endtask

  task automatic drive_all();
    fork
      drive_ch(0, 0);
      drive_ch(1, 0);
      drive_ch(2, 0);
      drive_ch(3, 0);
    join
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_q.size() > 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R7 packet not completed", 64'(exp_q.size()), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [3:0] dis, input logic [7:0] sh);
    @(negedge clk);
    ctl_we = 1'b1; ctl_disable = dis; ctl_bc_shift = sh;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic set_round(input int b0, b1, b2, b3, input int f0, f1, f2, f3,
                           input int l0, l1, l2, l3);
    rbc = '{b0, b1, b2, b3};
    rbf = '{f0, f1, f2, f3};
    rln = '{l0, l1, l2, l3};
  endtask

  // Cycle-by-cycle comparison of the output against the expected queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (in_ready[0] == 1'b0) saw_full0 = 1'b1;
      if (pend && !out_valid) begin
        fails++;
        $display("FAIL R8 idle cycle inside packet actual=0 expected=1 at %0t", $time);
      end
      if (out_valid) begin
        any_valid = 1'b1;
        vectors++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected output actual=%h expected=none at %0t", out_data, $time);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_data !== e[31:0]) begin
            fails++;
            $display("FAIL %s data actual=%h expected=%h at %0t", t, out_data, e[31:0], $time);
          end else if (out_last !== e[32]) begin
            fails++;
            $display("FAIL R8 last flag actual=%0b expected=%0b at %0t", out_last, e[32], $time);
          end
        end
      end
      pend = out_valid && !out_last;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_disable = '0; ctl_bc_shift = '0;
    tb_v = '0; tb_l = '0; pend = 0; any_valid = 0; saw_full0 = 0;
    for (int c = 0; c < 4; c++) tb_d[c] = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 4'hF, "R10 in_ready in reset", 64'(in_ready), 64'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 4'hF, "R10 in_ready after reset", 64'(in_ready), 64'hF);

    // R6 reset defaults (all enabled, shift 41), R1/R3/R4 plain packets
    set_round(32, 32, 32, 32, 2, 2, 2, 2, 3, 5, 8, 4);
    gen_frag(0, 0); gen_frag(1, 0); gen_frag(2, 0); gen_frag(3, 0);
    build_exp(4'h0, 8'd41, 0, "R6");
    set_round(33, 33, 33, 33, 3, 3, 3, 3, 6, 3, 3, 10);
    gen_frag(0, 1); gen_frag(1, 1); gen_frag(2, 1); gen_frag(3, 1);
    build_exp(4'h0, 8'd41, 1, "R3");
    drive_all();
    wait_drain();

    // R5 mismatch flags: bunch only, buffer only, both
    set_round(30, 30, 31, 30, 1, 1, 1, 1, 4, 4, 4, 4);
    for (int c = 0; c < 4; c++) gen_frag(c, 2);
    build_exp(4'h0, 8'd41, 2, "R3");
    set_round(40, 40, 40, 40, 0, 0, 0, 2, 3, 7, 3, 5);
    for (int c = 0; c < 4; c++) gen_frag(c, 3);
    build_exp(4'h0, 8'd41, 3, "R3");
    set_round(50, 51, 50, 50, 1, 1, 0, 1, 5, 3, 6, 3);
    for (int c = 0; c < 4; c++) gen_frag(c, 4);
    build_exp(4'h0, 8'd41, 4, "R3");
    drive_all();
    wait_drain();

    // R6 masking: channels 0 and 2 off, then only channel 0 on
    write_ctl(4'b0101, 8'd41);
    set_round(0, 60, 0, 61, 0, 2, 0, 2, 0, 4, 0, 6);
    gen_frag(1, 5); gen_frag(3, 5);
    build_exp(4'b0101, 8'd41, 5, "R6");
    drive_all();
    wait_drain();
    write_ctl(4'b1110, 8'd7);
    set_round(70, 0, 0, 0, 3, 0, 0, 0, 9, 0, 0, 0);
    gen_frag(0, 6);
    build_exp(4'b1110, 8'd7, 6, "R6");
    drive_all();
    wait_drain();

    // R3 shift wraps past 255
    write_ctl(4'b0000, 8'd250);
    set_round(10, 10, 10, 10, 1, 1, 1, 1, 3, 3, 3, 3);
    for (int c = 0; c < 4; c++) gen_frag(c, 7);
    build_exp(4'h0, 8'd250, 7, "R3");
    drive_all();
    wait_drain();

    // R7 all channels disabled: nothing comes out, fragments are kept
    write_ctl(4'b1111, 8'd41);
    set_round(80, 80, 80, 80, 0, 0, 0, 0, 4, 5, 3, 6);
    for (int c = 0; c < 4; c++) gen_frag(c, 8);
    any_valid = 0;
    drive_all();
    repeat (40) @(negedge clk);
    check(any_valid == 0, "R7 output while all disabled", 64'(any_valid), 64'd0);
    build_exp(4'h0, 8'd41, 8, "R7");
    write_ctl(4'b0000, 8'd41);
    wait_drain();

    // R7 three channels complete, fourth held back
    set_round(90, 90, 90, 90, 2, 2, 2, 2, 5, 3, 4, 7);
    for (int c = 0; c < 4; c++) gen_frag(c, 9);
    any_valid = 0;
    fork
      drive_ch(0, 0);
      drive_ch(1, 0);
      drive_ch(2, 0);
    join
    repeat (40) @(negedge clk);
    check(any_valid == 0, "R7 output before all complete", 64'(any_valid), 64'd0);
    build_exp(4'h0, 8'd41, 9, "R7");
    drive_ch(3, 0);
    wait_drain();

    // R9 back-pressure: long fragments with a late channel fill the buffers
    saw_full0 = 0;
    set_round(100, 100, 100, 100, 1, 1, 1, 1, 14, 14, 14, 14);
    for (int c = 0; c < 4; c++) gen_frag(c, 10);
    build_exp(4'h0, 8'd41, 10, "R9");
    set_round(101, 101, 101, 101, 2, 2, 2, 2, 14, 12, 16, 13);
    for (int c = 0; c < 4; c++) gen_frag(c, 11);
    build_exp(4'h0, 8'd41, 11, "R9");
    fork
      drive_ch(0, 0);
      drive_ch(1, 0);
      drive_ch(2, 0);
      drive_ch(3, 80);
    join
    wait_drain();
    check(saw_full0 == 1, "R9 in_ready never dropped", 64'(saw_full0), 64'd1);

    finish_run();
  end

endmodule